// File: doc/BRIEF.md
# Mini UART Register Front-End

This block is the register-facing half of a simplified serial port. A host reaches it through a 32-bit register port. The port has a byte offset, separate read and write strobes, write data and registered read data. Incoming bytes arrive on a valid/ready stream and are queued in a circular receive buffer. The host drains that buffer by reading the data register. A write to the data register hands its low byte to an outgoing valid/ready stream. The serialiser is assumed to take bytes at once, so the transmit side is always reported as idle and empty.

The block keeps a two-bit interrupt enable and derives one level-sensitive interrupt line from it. It also derives an interrupt identification code, a line status word and an extended status word that carries the receive fill level. Bit timing, baud generation, line and modem control and scratch storage are handled elsewhere or not at all. Their offsets read as zero.

Top module: `murf_top`

## Requirements
- R1: After synchronous reset, the following all hold: interrupt enables are zero, the receive buffer is empty, `irq` is low, `tx_valid` is low, `rx_ready` is high and `reg_rdata` is zero.
- R2: A read returns its value on `reg_rdata` after the next rising edge and keeps it until the next read. Offset 0x04 reads 1 and offset 0x60 reads 0x3. Every offset outside {0x00, 0x04, 0x40, 0x44, 0x48, 0x54, 0x60, 0x64} reads 0. A write to such an offset changes no register.
- R3: A write to offset 0x44 stores only write-data bits [1:0] (bit 0 = receive enable, bit 1 = transmit enable). A read of 0x44 returns those bits ORed with 0xC0.
- R4: `irq` is high exactly when (receive enable and buffer not empty) or transmit enable.
- R5: A read of offset 0x48 returns 0xC0 | code | idle. code is 0x4 when the receive enable is set and the buffer holds data, and 0x2 otherwise. idle is 1 only when `irq` is low.
- R6: A write to offset 0x48 with bit 1 set empties the receive buffer. `rx_ready` is low during that write cycle. A write with bit 1 clear leaves the fill level unchanged.
- R7: A read of offset 0x54 returns 0x60, with bit 0 set when the buffer holds at least one byte.
- R8: A read of offset 0x64 returns 0x30E, with bit 0 set when data is present and the fill count placed at bits [19:16].
- R9: A read of offset 0x40 returns the oldest byte in bits [7:0] and removes it. A read of an empty buffer leaves the fill count at zero.
- R10: The receive buffer holds DEPTH bytes (default 8) in arrival order across pointer wrap. `rx_ready` is low while it is full, so no byte is taken or lost.
- R11: A read of offset 0x00 returns 1 when `irq` is high and 0 otherwise.
- R12: A write to offset 0x40 raises `tx_valid` with write-data bits [7:0] on `tx_data`. Both are held until `tx_ready` is seen high at a clock edge. A data write while a byte is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Buffer can accept a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Serialiser takes the byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench walks the fill level from empty to full and back. A wrong count field or a lost full stall would show as a bad status word or as an extra byte that overwrites the oldest one. Every interrupt-enable value is combined with an empty and a non-empty buffer. This catches a swapped identification code, a transmit interrupt that depends on data, or an idle bit that ignores the transmit source. The bench also fills across the pointer wrap to catch ordering bugs. It flushes while a byte is offered, to catch a flush that keeps a stray byte. It writes the data register twice while the serialiser stalls, to catch a holding register that gets overwritten.

// File: rtl/murf_pkg.sv
package murf_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SUM  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_IE   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_ID   = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_LS   = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_XS   = 8'h64;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SUM, SEL_ENA, SEL_DATA, SEL_IE,
    SEL_ID, SEL_LS, SEL_CTL, SEL_XS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_SUM:  return SEL_SUM;
      OFS_ENA:  return SEL_ENA;
      OFS_DATA: return SEL_DATA;
      OFS_IE:   return SEL_IE;
      OFS_ID:   return SEL_ID;
      OFS_LS:   return SEL_LS;
      OFS_CTL:  return SEL_CTL;
      OFS_XS:   return SEL_XS;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/murf_rxq.sv
module murf_rxq #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             flush,
  input  logic             cap,
  output logic [W-1:0]     head_q,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] head;
  logic [PTR_W-1:0] tail;
  logic [PTR_W:0]   sum;
  logic             do_push, do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    sum  = {1'b0, head} + (PTR_W+1)'(cnt);
    tail = (sum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(sum - (PTR_W+1)'(DEPTH)) : PTR_W'(sum);
  end

  // storage and head capture kept reset-free for block RAM inference
  always_ff @(posedge clk) begin
    if (do_push) mem[tail] <= push_data;
    if (cap)     head_q    <= mem[head];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      cnt  <= '0;
    end else begin
      if (do_pop) head <= (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
      if (flush) cnt <= '0;
      else       cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/murf_txhold.sv
module murf_txhold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (valid) begin
      if (ready) valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end
  end
endmodule

// File: rtl/murf_top.sv
module murf_top
  import murf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              irq
);
  reg_sel_e          sel;
  logic [1:0]        ier_q;
  logic [CNT_W-1:0]  fill_cnt;
  logic [BYTE_W-1:0] head_byte;
  logic              full, empty, flush, push, rx_pend;
  logic              rd_is_data_q;
  logic [DATA_W-1:0] rdata_q, rd_val;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[DATA_W-1:BYTE_W]};
  assign sel      = decode_ofs(reg_addr);
  assign flush    = reg_wr && (sel == SEL_ID) && reg_wdata[1];
  assign rx_ready = !full && !flush;
  assign push     = rx_valid && rx_ready;
  assign rx_pend  = ier_q[0] && !empty;
  assign irq      = rx_pend || ier_q[1];

  murf_rxq #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
    .clk(clk), .rst(rst),
    .push(push), .push_data(rx_data),
    .pop(reg_rd && (sel == SEL_DATA)), .flush(flush),
    .cap(reg_rd && (sel == SEL_DATA)),
    .head_q(head_byte), .cnt(fill_cnt), .full(full), .empty(empty)
  );

  murf_txhold #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst),
    .load(reg_wr && (sel == SEL_DATA)), .load_data(reg_wdata[BYTE_W-1:0]),
    .ready(tx_ready), .valid(tx_valid), .data(tx_data)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_SUM: rd_val = DATA_W'(irq);
      SEL_ENA: rd_val = 32'h1;
      SEL_IE:  rd_val = 32'hC0 | DATA_W'(ier_q);
      SEL_ID:  rd_val = 32'hC0 | (rx_pend ? 32'h4 : 32'h2) | DATA_W'(!irq);
      SEL_LS:  rd_val = 32'h60 | DATA_W'(!empty);
      SEL_CTL: rd_val = 32'h3;
      SEL_XS:  rd_val = 32'h30E | DATA_W'(!empty) | (DATA_W'(fill_cnt) << 16);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q        <= '0;
      rdata_q      <= '0;
      rd_is_data_q <= 1'b0;
    end else begin
      if (reg_wr && (sel == SEL_IE)) ier_q <= reg_wdata[1:0];
      if (reg_rd) begin
        rdata_q      <= rd_val;
        rd_is_data_q <= (sel == SEL_DATA);
      end
    end
  end

  assign reg_rdata = rd_is_data_q ? DATA_W'(head_byte) : rdata_q;
endmodule

// File: rtl/murf_chk.sv
module murf_chk
  import murf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              irq,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic [1:0]        ier_bits
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));

  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == CNT_W'(DEPTH)) |-> !rx_ready);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_ID && reg_wdata[1]) |=> (fill_cnt == '0));

  // R9
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_DATA && fill_cnt != '0 && !(rx_valid && rx_ready)
     && !(reg_wr && reg_addr == OFS_ID && reg_wdata[1]))
    |=> (fill_cnt + 1'b1 == $past(fill_cnt)));

  // R4
  tx_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ier_bits[1] |-> irq);
endmodule

bind murf_top murf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq),
  .fill_cnt(fill_cnt), .ier_bits(ier_q)
);

// File: tb/sim_murf_top.sv
module sim_murf_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  murf_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] xs_exp(input int k);
    return 32'h30E | ((k != 0) ? 32'h1 : 32'h0) | (32'(k) << 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    chk("R1 rdata", reg_rdata, 0);
    rd(8'h64, v); chk("R1 empty", v, 32'h30E);
    rd(8'h44, v); chk("R1 ier", v, 32'hC0);

    // R2 constants and unmapped offsets
    rd(8'h04, v); chk("R2 enables", v, 1);
    rd(8'h60, v); chk("R2 control", v, 3);
    for (int a = 0; a < 256; a += 4) begin
      if (!(a inside {8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h54, 8'h60, 8'h64})) begin
        rd(8'(a), v); chk("R2 unmapped read", v, 0);
      end
    end
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R2 ignored write ier", v, 32'hC0);
    chk("R2 ignored write irq", 32'(irq), 0);
    chk("R2 ignored write tx", 32'(tx_valid), 0);

    // R3 R4 R5 R11 sweep enables x fill {0,1}
    for (int f = 0; f < 2; f++) begin
      if (f == 1) push(8'h3C);
      for (int e = 0; e < 4; e++) begin
        bit rxp, ip;
        rxp = (e[0] == 1'b1) && (f == 1);
        ip  = rxp || (e[1] == 1'b1);
        wr(8'h44, 32'hFFFF_FFFC | 32'(e));
        rd(8'h44, v); chk("R3 ier readback", v, 32'hC0 | 32'(e));
        chk("R4 irq level", 32'(irq), 32'(ip));
        rd(8'h48, v); chk("R5 ident", v, 32'hC0 | (rxp ? 32'h4 : 32'h2) | (ip ? 32'h0 : 32'h1));
        rd(8'h00, v); chk("R11 summary", v, 32'(ip));
      end
    end
    wr(8'h44, 0);
    wr(8'h48, 32'h2);

    // R7 R8 R10 fill sweep
    for (int k = 0; k <= DEPTH; k++) begin
      rd(8'h54, v); chk("R7 line status", v, 32'h60 | ((k != 0) ? 32'h1 : 32'h0));
      rd(8'h64, v); chk("R8 ext status", v, xs_exp(k));
      chk("R10 rx_ready", 32'(rx_ready), (k < DEPTH) ? 1 : 0);
      if (k < DEPTH) push(8'hA0 + 8'(k));
    end
    @(negedge clk); rx_data = 8'hEE; rx_valid = 1'b1;
    repeat (3) @(negedge clk);
    rx_valid = 1'b0;
    rd(8'h64, v); chk("R10 full no take", v, xs_exp(DEPTH));

    // R9 pops in order
    for (int k = 0; k < DEPTH; k++) begin
      rd(8'h40, v); chk("R9 pop byte", v, 32'hA0 + 32'(k));
      rd(8'h64, v); chk("R9 count after pop", v, xs_exp(DEPTH - 1 - k));
    end
    rd(8'h40, v);
    rd(8'h64, v); chk("R9 empty read count", v, 32'h30E);
    rd(8'h54, v); chk("R9 empty read ls", v, 32'h60);

    // R10 wraparound ordering
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) begin
      rd(8'h40, v); chk("R10 pre-wrap pop", v, 32'h10 + 32'(i));
    end
    for (int i = 0; i < DEPTH; i++) push(8'hB0 + 8'(i));
    chk("R10 full after wrap", 32'(rx_ready), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h40, v); chk("R10 wrap order", v, 32'hB0 + 32'(i));
    end

    // R6 flush
    for (int i = 0; i < 4; i++) push(8'h60 + 8'(i));
    wr(8'h48, 32'h1);
    rd(8'h64, v); chk("R6 no flush bit1 clear", v, xs_exp(4));
    @(negedge clk); reg_addr = 8'h48; reg_wdata = 32'h2; reg_wr = 1'b1;
    rx_data = 8'h77; rx_valid = 1'b1;
    #1; chk("R6 rx_ready during flush", 32'(rx_ready), 0);
    @(negedge clk); reg_wr = 1'b0; rx_valid = 1'b0;
    rd(8'h64, v); chk("R6 flushed", v, 32'h30E);
    push(8'h5A);
    rd(8'h40, v); chk("R6 after flush byte", v, 32'h5A);

    // R12 transmit holding
    tx_ready = 1'b0;
    wr(8'h40, 32'h1234_56C3);
    chk("R12 tx_valid", 32'(tx_valid), 1);
    chk("R12 tx_data", 32'(tx_data), 32'hC3);
    repeat (3) @(negedge clk);
    chk("R12 held valid", 32'(tx_valid), 1);
    wr(8'h40, 32'h99);
    chk("R12 pending write ignored", 32'(tx_data), 32'hC3);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R12 released", 32'(tx_valid), 0);
    wr(8'h40, 32'h7E);
    chk("R12 second byte valid", 32'(tx_valid), 1);
    chk("R12 second byte data", 32'(tx_data), 32'h7E);
    @(negedge clk);
    chk("R12 second byte taken", 32'(tx_valid), 0);
    tx_ready = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule